// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds general registers 0 to 14 of a processor core. Some of those registers exist several times over, one copy per operating mode. The core supplies its current 5-bit mode code. The block uses that code to steer every access to the physical copy that belongs to the mode. The program counter, status-word handling, checks on mode changes and exception sequencing all live outside this block.

The block has three access ports. Two read ports are combinational, each addressed by a 4-bit register number. One write port is synchronous and commits on the rising clock edge. A bank-override input lets a debugger reach the User copies from any mode.

Register number 15 is not stored here. Reads of it return zero, and writes to it are dropped.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0 to 7 are a single set of copies that every mode reads and writes.
- R2: In mode 5'b10001 (fast interrupt), registers 8 to 12 map to private copies that no other mode reaches. In every other mode, registers 8 to 12 map to one shared set.
- R3: Registers 13 and 14 have a separate copy for each of these mode codes: 5'b10000 (User), 5'b10001 (fast interrupt), 5'b10010 (interrupt), 5'b10011 (supervisor), 5'b10111 (abort) and 5'b11011 (undefined).
- R4: Mode code 5'b11111 (system) accesses the User copies of every register.
- R5: A mode code outside those listed in R3 and R4 accesses the User copies.
- R6: While user_bank_i is 1, every read and write maps to the User copies, whatever the mode code.
- R7: A write commits on the rising edge, into the copy selected by the mode and user_bank_i of that cycle. A read of the same register in that cycle returns the value held before the write.
- R8: A read of register number 15 returns zero. A write to register number 15 changes no stored register.
- R9: While rst is high, every physical copy is cleared to zero on each rising edge.
- R10: The two read ports are independent. Addressed with the same register number in the same cycle, they return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode code |
| user_bank_i | input | 1 | Force all accesses to the User copies |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | DATA_W | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register number |
| wr_data | input | DATA_W | Write data |

## Verification
A wrong steering decision stays hidden until the affected register is read back in a mode that maps to a different copy. When that happens, either another mode's value or a stale value appears on the read port in the same cycle as the read. The bench therefore writes a value that is unique per mode and per register into every slot, through every mode code including one unlisted code. It then reads every register back from every mode, so any copy that was mixed up shows as a wrong value on the port. Write-versus-read ordering is visible one cycle after the write edge. Corruption of storage, such as a write to register 15 or a leak between banks, shows on the next read of that slot.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int MODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam int NUM_BANKS = 6;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/rbank_mode_dec.sv
module rbank_mode_dec
  import rbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              user_bank_i,
  output bank_e             bank_o
);
  always_comb begin
    bank_o = BK_USR;
    if (!user_bank_i) begin
      case (mode_i)
        MD_FIQ:  bank_o = BK_FIQ;
        MD_IRQ:  bank_o = BK_IRQ;
        MD_SVC:  bank_o = BK_SVC;
        MD_ABT:  bank_o = BK_ABT;
        MD_UND:  bank_o = BK_UND;
        default: bank_o = BK_USR;
      endcase
    end
  end
endmodule

// File: rtl/rbank_map.sv
module rbank_map
  import rbank_pkg::*;
#(
  parameter int FIQ_FIRST = 8,
  parameter int PIDX_W    = 5
) (
  input  bank_e              bank_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PIDX_W-1:0]  phys_o,
  output logic               hit_o
);
  localparam int FIQ_CNT   = SP_IDX - FIQ_FIRST;
  localparam int FIQ_BASE  = SP_IDX;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;

  int ix;
  int p;

  always_comb begin
    ix    = int'(idx_i);
    p     = 0;
    hit_o = (ix <= LR_IDX);
    if (ix < FIQ_FIRST) begin
      p = ix;
    end else if (ix < SP_IDX) begin
      p = (bank_i == BK_FIQ) ? (FIQ_BASE + ix - FIQ_FIRST) : ix;
    end else if (ix <= LR_IDX) begin
      p = PAIR_BASE + 2 * int'(bank_i) + (ix - SP_IDX);
    end
    phys_o = PIDX_W'(p);
  end
endmodule

// File: rtl/rbank_store.sv
module rbank_store #(
  parameter int DATA_W = 32,
  parameter int PHYS_N = 30,
  parameter int PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [PIDX_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PIDX_W-1:0] raddr_a_i,
  input  logic [PIDX_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [PHYS_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

  // R7
  store_write_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mem[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbank_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FIQ_FIRST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode_i,
  input  logic              user_bank_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int FIQ_CNT = SP_IDX - FIQ_FIRST;
  localparam int PHYS_N  = SP_IDX + FIQ_CNT + 2 * NUM_BANKS;
  localparam int PIDX_W  = $clog2(PHYS_N);
  localparam int NPORTS  = 3;

  bank_e             bank;
  logic [IDX_W-1:0]  map_idx  [NPORTS];
  logic [PIDX_W-1:0] map_phys [NPORTS];
  logic              map_hit  [NPORTS];
  logic [DATA_W-1:0] st_a, st_b;
  logic              st_we;

  rbank_mode_dec u_dec (
    .mode_i      (mode_i),
    .user_bank_i (user_bank_i),
    .bank_o      (bank)
  );

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar g = 0; g < NPORTS; g++) begin : g_map
    rbank_map #(.FIQ_FIRST(FIQ_FIRST), .PIDX_W(PIDX_W)) u_map (
      .bank_i (bank),
      .idx_i  (map_idx[g]),
      .phys_o (map_phys[g]),
      .hit_o  (map_hit[g])
    );
  end

  assign st_we = wr_en & map_hit[2];

  rbank_store #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .PIDX_W(PIDX_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .we_i      (st_we),
    .waddr_i   (map_phys[2]),
    .wdata_i   (wr_data),
    .raddr_a_i (map_phys[0]),
    .raddr_b_i (map_phys[1]),
    .rdata_a_o (st_a),
    .rdata_b_o (st_b)
  );

  assign rd_a_data = map_hit[0] ? st_a : '0;
  assign rd_b_data = map_hit[1] ? st_b : '0;

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  // R8
  r15_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 4'hF) |-> (rd_a_data == '0));

  // R8
  r15_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'hF) |-> !st_we);

  // R7
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != 4'hF) |=>
      ((mode_i == $past(mode_i) && user_bank_i == $past(user_bank_i) &&
        rd_a_idx == $past(wr_idx)) -> (rd_a_data == $past(wr_data))));

  // R6
  ovr_bank_chk: assert property (@(posedge clk) disable iff (rst)
    user_bank_i |-> (bank == BK_USR));

  // R2
  fiq_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (bank == BK_FIQ) |-> (mode_i == MD_FIQ && !user_bank_i));

  // R10
  port_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = 5'b10000;
  logic        user_bank_i = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] ea;
    logic [31:0] eb;
    string       ta;
    string       tb;
  } item_t;

  item_t q[$];
  event  chk_ev;
  logic [31:0] model [int];

  localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                      5'b10111, 5'b11011, 5'b11111, 5'b00101};

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .mode_i(mode_i), .user_bank_i(user_bank_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic int bank_of(logic [4:0] m, logic o);
    if (o) return 0;
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic int key(logic [4:0] m, logic o, int r);
    int b;
    b = bank_of(m, o);
    if (r < 8) return r;
    if (r < 13) return (b == 1) ? 100 + r : r;
    return b * 100 + r;
  endfunction

  function automatic logic [31:0] expect_rd(logic [4:0] m, logic o, int r);
    int k;
    if (r == 15) return '0;
    k = key(m, o, r);
    return model.exists(k) ? model[k] : '0;
  endfunction

  function automatic string tag_of(logic [4:0] m, logic o, int r);
    if (r == 15) return "R8";
    if (o) return "R6";
    if (r < 8) return "R1";
    if (r < 13) return "R2";
    if (m == 5'b11111) return "R4";
    if (m == 5'b10000 || bank_of(m, 1'b0) != 0) return "R3";
    return "R5";
  endfunction

  task automatic cyc(input logic [4:0] m, input logic o, input int ra, input int rb,
                     input logic we, input int wi, input logic [31:0] wd, input string tg);
    item_t it;
    @(negedge clk);
    mode_i = m; user_bank_i = o;
    rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    it.ea = expect_rd(m, o, ra);
    it.eb = expect_rd(m, o, rb);
    it.ta = (tg != "") ? tg : tag_of(m, o, ra);
    it.tb = (tg != "") ? tg : tag_of(m, o, rb);
    q.push_back(it);
    #1 -> chk_ev;
    @(posedge clk);
    if (we && wi != 15) model[key(m, o, wi)] = wd;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(chk_ev);
      it = q.pop_front();
      checks += 2;
      if (rd_a_data !== it.ea) begin
        errors++;
        $display("FAIL %s port A idx %0d mode %b: actual %h expected %h",
                 it.ta, rd_a_idx, mode_i, rd_a_data, it.ea);
      end
      if (rd_b_data !== it.eb) begin
        errors++;
        $display("FAIL %s port B idx %0d mode %b: actual %h expected %h",
                 it.tb, rd_b_idx, mode_i, rd_b_data, it.eb);
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9: all copies read zero after reset
    for (int r = 0; r < 15; r++) cyc(5'b10000, 1'b0, r, 14 - r, 1'b0, 0, '0, "R9");
    for (int r = 8; r < 15; r++) cyc(5'b10001, 1'b0, r, r, 1'b0, 0, '0, "R9");

    // fill every slot from every mode code (R1-R5 mapping, R8 writes to 15)
    for (int mi = 0; mi < 8; mi++)
      for (int r = 0; r < 16; r++)
        cyc(MODES[mi], 1'b0, r, (r + 1) % 16, 1'b1, r,
            32'hA000_0000 | (32'(mi) << 16) | 32'(r), "");

    // read everything back from every mode
    for (int mi = 0; mi < 8; mi++)
      for (int r = 0; r < 16; r++)
        cyc(MODES[mi], 1'b0, r, 15 - r, 1'b0, 0, '0, "");

    // R6: override writes from fast interrupt mode land in User copies
    cyc(5'b10001, 1'b1, 9, 13, 1'b1, 9, 32'h5555_0009, "");
    cyc(5'b10001, 1'b1, 13, 9, 1'b1, 13, 32'h6666_000D, "");
    cyc(5'b10001, 1'b1, 9, 13, 1'b0, 0, '0, "R6");
    cyc(5'b10000, 1'b0, 9, 13, 1'b0, 0, '0, "R6");
    cyc(5'b10001, 1'b0, 9, 13, 1'b0, 0, '0, "R6");
    cyc(5'b10010, 1'b1, 14, 13, 1'b0, 0, '0, "R6");

    // R7: same-cycle read returns old value, new value next cycle
    cyc(5'b10010, 1'b0, 13, 14, 1'b1, 13, 32'hDEAD_BEEF, "R7");
    cyc(5'b10010, 1'b0, 13, 14, 1'b0, 0, '0, "R7");
    cyc(5'b10011, 1'b0, 13, 13, 1'b0, 0, '0, "R7");

    // R8: write to 15 changes nothing visible
    cyc(5'b10000, 1'b0, 15, 0, 1'b1, 15, 32'hFFFF_FFFF, "R8");
    for (int r = 0; r < 15; r++) cyc(5'b10000, 1'b0, r, 15, 1'b0, 0, '0, "R8");

    // R10: both ports on the same register
    for (int mi = 0; mi < 8; mi++) cyc(MODES[mi], 1'b0, 10 + (mi % 5), 10 + (mi % 5), 1'b0, 0, '0, "R10");

    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule